// File: doc/BRIEF.md
# Paired-channel PWM tick prescaler

This block produces the counting tick enables for two PWM channels that form a pair. Two reference tick streams arrive as single-cycle enables in the system clock domain. A select bit in the pair configuration word picks one of them. A gate bit then lets the selected stream through, and a shared power-of-two divider turns it into the pair source tick. Each channel divides that pair source by its own linear prescaler to make its counting tick.

Each channel also has a bypass output. This output carries the undivided pair source tick, gated by the channel's enable bit. A registered bypass select tells the channel logic downstream which of the two ticks it should count on. No derived clocks are generated. Every output is a registered single-cycle enable in the one clock domain.

Top module: `pwmpre_pair`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ch_tick`, `byp_tick` and `byp_sel` are all zero.
- R2: `pair_cfg[7]` picks the reference: 0 selects `ref_a_tick`, 1 selects `ref_b_tick`. The stream that is not selected has no effect on any output.
- R3: When `pair_cfg[4]` (gate) is 0, both dividers restart from zero. In the following cycle no `ch_tick` or `byp_tick` bit is set.
- R4: With gate set and m = `pair_cfg[3:0]` in 0..8, the pair source fires once for every 2^m selected reference ticks. The count starts from a divider that was just restarted.
- R5: A code m greater than 8 divides like m = 8 (by 256).
- R6: Channel i divides pair source ticks by k+1, where k = `ch_presc[8*i+7:8*i]`. With k = 0, every pair source tick produces a channel tick.
- R7: `byp_sel[0]` follows `pair_cfg[5]` and `byp_sel[1]` follows `pair_cfg[6]`, one cycle later.
- R8: `byp_tick[i]` repeats each pair source tick only while `ch_enable[i]` is 1. The pair source tick is taken before the per-channel divider.
- R9: The two channels keep independent prescale counters that share the one pair source.
- R10: `ch_tick` and `byp_tick` pulse two clock edges after the edge that samples the reference tick which completes a divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_a_tick | input | 1 | Reference tick stream A |
| ref_b_tick | input | 1 | Reference tick stream B |
| pair_cfg | input | 8 | Pair config: [3:0] m, [4] gate, [5] bypass ch0, [6] bypass ch1, [7] source |
| ch_presc | input | 16 | Per-channel prescale k, channel i in bits [8i+7:8i] |
| ch_enable | input | 2 | Per-channel enable, gates the bypass tick |
| ch_tick | output | 2 | Divided per-channel tick enables |
| byp_tick | output | 2 | Undivided pair source tick per channel, gated |
| byp_sel | output | 2 | Registered bypass select per channel |

## Verification
The assertions take for granted that every input is synchronous to `clk` and that the reference ticks are plain enables of any density. Under those assumptions every output tick can be traced back to a reference tick two edges earlier. The stimulus drives every input on the falling edge only. It changes the configuration and prescale words mid-stream, including lowering k below a running count and switching gate and source while ticks are in flight. A per-cycle behavioural model in the bench follows each of these changes, so the checks stay meaningful across them.

// File: rtl/pwmpre_pkg.sv
package pwmpre_pkg;
  localparam int N_CH       = 2;
  localparam int CFG_W      = 8;
  localparam int MCODE_W    = 4;
  localparam int MCODE_LSB  = 0;
  localparam int GATE_BIT   = 4;
  localparam int BYP_LSB    = 5;   // channel i bypass at BYP_LSB+i
  localparam int SRC_BIT    = 7;

  function automatic int unsigned sat_code(input int unsigned code, input int unsigned lim);
    return (code > lim) ? lim : code;
  endfunction
endpackage

// File: rtl/pwmpre_pair_src.sv
// Shared stage: source mux, gate, power-of-two divider (R2, R3, R4, R5)
module pwmpre_pair_src #(
  parameter int MCODE_W  = 4,
  parameter int MAX_LOG2 = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_a,
  input  logic               ref_b,
  input  logic               src_sel,
  input  logic               gate_en,
  input  logic [MCODE_W-1:0] m_code,
  output logic               pair_tick
);
  localparam int CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    ratio;
  logic [CNT_W-1:0]  wrap_at;
  logic              sel_tick;
  int unsigned       m_eff;

  always_comb begin
    m_eff    = pwmpre_pkg::sat_code(int'(m_code), MAX_LOG2);
    ratio    = (CNT_W+1)'(1) << m_eff;
    wrap_at  = CNT_W'(ratio - 1'b1);
    sel_tick = src_sel ? ref_b : ref_a;
  end

  always_ff @(posedge clk) begin
    if (rst || !gate_en) begin
      cnt_q     <= '0;
      pair_tick <= 1'b0;
    end else if (sel_tick) begin
      if (cnt_q >= wrap_at) begin
        cnt_q     <= '0;
        pair_tick <= 1'b1;
      end else begin
        cnt_q     <= cnt_q + 1'b1;
        pair_tick <= 1'b0;
      end
    end else begin
      pair_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pwmpre_ch_div.sv
// Per-channel linear prescaler (R6) and gated bypass tick (R8)
module pwmpre_ch_div #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gate_en,
  input  logic               pair_tick,
  input  logic [PRESC_W-1:0] k_val,
  input  logic               ch_en,
  output logic               ch_tick,
  output logic               byp_tick
);
  logic [PRESC_W-1:0] kcnt_q;

  always_ff @(posedge clk) begin
    if (rst || !gate_en) begin
      kcnt_q   <= '0;
      ch_tick  <= 1'b0;
      byp_tick <= 1'b0;
    end else begin
      byp_tick <= pair_tick & ch_en;
      ch_tick  <= 1'b0;
      if (pair_tick) begin
        if (kcnt_q >= k_val) begin
          kcnt_q  <= '0;
          ch_tick <= 1'b1;
        end else begin
          kcnt_q  <= kcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwmpre_pair.sv
module pwmpre_pair
  import pwmpre_pkg::*;
#(
  parameter int PRESC_W  = 8,
  parameter int MAX_LOG2 = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ref_a_tick,
  input  logic                      ref_b_tick,
  input  logic [CFG_W-1:0]          pair_cfg,
  input  logic [N_CH*PRESC_W-1:0]   ch_presc,
  input  logic [N_CH-1:0]           ch_enable,
  output logic [N_CH-1:0]           ch_tick,
  output logic [N_CH-1:0]           byp_tick,
  output logic [N_CH-1:0]           byp_sel
);
  logic pair_tick;
  logic gate_en;

  assign gate_en = pair_cfg[GATE_BIT];

  pwmpre_pair_src #(
    .MCODE_W  (MCODE_W),
    .MAX_LOG2 (MAX_LOG2)
  ) u_src (
    .clk       (clk),
    .rst       (rst),
    .ref_a     (ref_a_tick),
    .ref_b     (ref_b_tick),
    .src_sel   (pair_cfg[SRC_BIT]),
    .gate_en   (gate_en),
    .m_code    (pair_cfg[MCODE_LSB +: MCODE_W]),
    .pair_tick (pair_tick)
  );

  for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
    pwmpre_ch_div #(.PRESC_W(PRESC_W)) u_div (
      .clk       (clk),
      .rst       (rst),
      .gate_en   (gate_en),
      .pair_tick (pair_tick),
      .k_val     (ch_presc[gi*PRESC_W +: PRESC_W]),
      .ch_en     (ch_enable[gi]),
      .ch_tick   (ch_tick[gi]),
      .byp_tick  (byp_tick[gi])
    );
  end

  // R7: registered bypass select
  always_ff @(posedge clk) begin
    if (rst) byp_sel <= '0;
    else     byp_sel <= pair_cfg[BYP_LSB +: N_CH];
  end
endmodule

// File: rtl/pwmpre_pair_chk.sv
module pwmpre_pair_chk
  import pwmpre_pkg::*;
#(
  parameter int PRESC_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ref_a_tick,
  input logic                    ref_b_tick,
  input logic [CFG_W-1:0]        pair_cfg,
  input logic [N_CH*PRESC_W-1:0] ch_presc,
  input logic [N_CH-1:0]         ch_enable,
  input logic [N_CH-1:0]         ch_tick,
  input logic [N_CH-1:0]         byp_tick,
  input logic [N_CH-1:0]         byp_sel
);
  p_gate_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !pair_cfg[GATE_BIT] |=> (ch_tick == '0 && byp_tick == '0));

  p_byp_sel_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (byp_sel == $past(pair_cfg[BYP_LSB +: N_CH])));

  p_byp_en_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((byp_tick & ~$past(ch_enable)) == '0));

  p_tick_origin_r10: assert property (@(posedge clk) disable iff (rst)
    (ch_tick != '0 || byp_tick != '0) |-> $past(ref_a_tick | ref_b_tick, 2));

  p_src_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (ch_tick != '0) |-> $past(pair_cfg[GATE_BIT], 2));
endmodule

bind pwmpre_pair pwmpre_pair_chk #(.PRESC_W(PRESC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ref_a_tick (ref_a_tick),
  .ref_b_tick (ref_b_tick),
  .pair_cfg   (pair_cfg),
  .ch_presc   (ch_presc),
  .ch_enable  (ch_enable),
  .ch_tick    (ch_tick),
  .byp_tick   (byp_tick),
  .byp_sel    (byp_sel)
);

// File: tb/pwmpre_pair_tb_top.sv
module pwmpre_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_a_tick = 1'b0;
  logic        ref_b_tick = 1'b0;
  logic [7:0]  pair_cfg = 8'h00;
  logic [15:0] ch_presc = 16'h0000;
  logic [1:0]  ch_enable = 2'b00;
  logic [1:0]  ch_tick, byp_tick, byp_sel;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  string cur_req = "R1";
  bit b_dense = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  pwmpre_pair dut_i (
    .clk(clk), .rst(rst), .ref_a_tick(ref_a_tick), .ref_b_tick(ref_b_tick),
    .pair_cfg(pair_cfg), .ch_presc(ch_presc), .ch_enable(ch_enable),
    .ch_tick(ch_tick), .byp_tick(byp_tick), .byp_sel(byp_sel)
  );

  // Behavioural reference model
  int  pcnt;
  int  kc [2];
  bit  m_pt;
  bit [1:0] m_ch, m_byp, m_sel;

  always @(posedge clk) begin
    bit [1:0] nch;
    bit [1:0] nbyp;
    int mm;
    int kk;
    bit stick;
    nch = 2'b00;
    nbyp = 2'b00;
    if (rst) begin
      pcnt = 0; kc[0] = 0; kc[1] = 0; m_pt = 0;
      m_ch = 0; m_byp = 0; m_sel = 0;
    end else begin
      if (!pair_cfg[4]) begin
        pcnt = 0; kc[0] = 0; kc[1] = 0; m_pt = 0;
      end else begin
        for (int i = 0; i < 2; i++) begin
          if (m_pt) begin
            kk = int'(ch_presc[i*8 +: 8]);
            if (kc[i] >= kk) begin kc[i] = 0; nch[i] = 1'b1; end
            else kc[i] = kc[i] + 1;
            nbyp[i] = ch_enable[i];
          end
        end
        mm = int'(pair_cfg[3:0]);
        if (mm > 8) mm = 8;
        stick = pair_cfg[7] ? ref_b_tick : ref_a_tick;
        m_pt = 1'b0;
        if (stick) begin
          pcnt = pcnt + 1;
          if (pcnt >= (1 << mm)) begin pcnt = 0; m_pt = 1'b1; end
        end
      end
      m_ch = nch; m_byp = nbyp; m_sel = {pair_cfg[6], pair_cfg[5]};
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    cyc++;
    n_cmp++;
    if (rst) begin
      if ({ch_tick, byp_tick, byp_sel} != 6'b0) begin
        n_bad++;
        $display("FAIL R1 reset outputs act=%b exp=000000", {ch_tick, byp_tick, byp_sel});
      end
    end else if (ch_tick !== m_ch) begin
      n_bad++;
      $display("FAIL %s,R6 ch_tick cyc %0d act=%b exp=%b", cur_req, cyc, ch_tick, m_ch);
    end else if (byp_tick !== m_byp) begin
      n_bad++;
      $display("FAIL %s,R8 byp_tick cyc %0d act=%b exp=%b", cur_req, cyc, byp_tick, m_byp);
    end else if (byp_sel !== m_sel) begin
      n_bad++;
      $display("FAIL %s,R7 byp_sel cyc %0d act=%b exp=%b", cur_req, cyc, byp_sel, m_sel);
    end
    ref_a_tick <= ($urandom_range(0, 2) != 0);
    ref_b_tick <= b_dense ? 1'b1 : ($urandom_range(0, 1) != 0);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        run(4);
        cur_req = "R1";          // first cycle after reset also zero
        @(negedge clk); rst = 1'b0;
        run(2);
        cur_req = "R4";          // source A, m=0, k=0 passes all
        pair_cfg = 8'h10; ch_presc = 16'h0000; ch_enable = 2'b11;
        run(40);
        cur_req = "R9";          // m=2, independent k0=3, k1=1
        pair_cfg = 8'h12; ch_presc = 16'h0103;
        run(120);
        cur_req = "R10";         // lower k below running count
        ch_presc = 16'h0000;
        run(30);
        cur_req = "R2";          // source B sparse, then A
        b_dense = 1'b0;
        pair_cfg = 8'h91; ch_presc = 16'h0201;
        run(80);
        pair_cfg = 8'h11;
        run(40);
        cur_req = "R3";          // gate off in flight, then on
        pair_cfg = 8'h01;
        run(20);
        pair_cfg = 8'h11;
        run(40);
        pair_cfg = 8'h81;
        run(5);
        cur_req = "R5";          // m=8 and saturated m=13 on dense B
        b_dense = 1'b1;
        pair_cfg = 8'h98; ch_presc = 16'h0100;
        run(600);
        pair_cfg = 8'h9D;
        run(600);
        cur_req = "R7";          // bypass selects
        pair_cfg = 8'hB0;
        run(10);
        pair_cfg = 8'hD0;
        run(10);
        cur_req = "R8";          // enable gating of bypass tick
        pair_cfg = 8'hF0; ch_enable = 2'b01;
        run(20);
        ch_enable = 2'b10;
        run(20);
        ch_enable = 2'b00;
        run(20);
        cur_req = "R6";          // large k
        pair_cfg = 8'h90; ch_presc = 16'h06FF; ch_enable = 2'b11;
        run(600);
      end
      begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule